// File: doc/BRIEF.md
# Vector index sequence generator

This block turns one 32-bit index-generation instruction word into a full vector-register result holding an arithmetic progression. Lane i gets `start + i*incr`, reduced to the lane width, so the sequence wraps. The start and the step each come either from a signed 5-bit immediate in the word or from a 64-bit scalar operand. The general register file has already read those operands and presents them on the block's inputs.

The element size field chooses 8-, 16-, 32- or 64-bit lanes at run time. The vector length is a parameter. Every lane is computed in parallel, and the result, the destination register number and a done pulse are registered once. A word that does not carry the fixed opcode bits raises an illegal pulse instead, and the result registers are left alone.

Top module: `vec_index_gen`

## Requirements
- R1: A word is legal when insn[31:24]=8'h04, insn[21]=1 and insn[15:12]=4'b0100. Any other word presented with valid_i pulses illegal_o for one cycle, and done_o stays low.
- R2: After an illegal word, vec_o and rd_o keep the values from the last legal result.
- R3: Form insn[11:10]=00: the start is the signed 5-bit insn[9:5] and the step is the signed 5-bit insn[20:16].
- R4: Form 10: the start is the signed immediate insn[9:5] and the step is the increment operand incr_reg_i.
- R5: Form 01: the start is the start operand start_reg_i and the step is the signed immediate insn[20:16].
- R6: Form 11: the start is start_reg_i and the step is incr_reg_i.
- R7: Size code insn[23:22] of 0, 1, 2 or 3 gives lanes of 8, 16, 32 or 64 bits, and there are VLEN/width lanes. Lane 0 sits in the least significant bits, and lane i occupies bits [i*w +: w].
- R8: Lane i holds (start + i*incr) mod 2^w, so a sequence that overflows wraps around.
- R9: For lanes narrower than 64 bits, only the low 32 bits of each scalar operand take part. For 64-bit lanes, all 64 bits are used.
- R10: 5-bit immediates are sign-extended, so a negative step gives a descending sequence.
- R11: A legal word with valid_i pulses done_o for exactly one cycle on the next clock. In that same cycle vec_o holds the result and rd_o holds insn[4:0]. Reset clears all outputs.
- R12: While valid_i is low, done_o and illegal_o stay low and vec_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word and operands are valid |
| insn_i | input | 32 | Instruction word |
| start_reg_i | input | 64 | Start scalar operand |
| incr_reg_i | input | 64 | Increment scalar operand |
| vec_o | output | VLEN | Packed result vector, lane 0 in the least significant bits |
| rd_o | output | 5 | Destination register number |
| done_o | output | 1 | One-cycle pulse: result written |
| illegal_o | output | 1 | One-cycle pulse: word failed the opcode match |

## Verification
Every result crosses one register, so done_o, illegal_o, vec_o and rd_o answer a request exactly one clock after the rising edge that sees valid_i. The bench drives each request on a falling edge and drops valid_i on the following falling edge. It compares the outputs at that second falling edge, which comes half a period after the capturing edge. On the falling edge after that it confirms that the pulses have ended and that the result registers hold their values through illegal and idle cycles.

// File: rtl/vig_pkg.sv
package vig_pkg;
  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_e;

  localparam int unsigned NUM_ESZ = 4;
  localparam int unsigned OP_W    = 64;
  localparam int unsigned IMM_W   = 5;
endpackage

// File: rtl/vig_decode.sv
module vig_decode
  import vig_pkg::*;
(
  input  logic [31:0]     insn_i,
  input  logic [OP_W-1:0] start_reg_i,
  input  logic [OP_W-1:0] incr_reg_i,
  output logic            legal_o,
  output esz_e            esz_o,
  output logic [4:0]      rd_o,
  output logic [OP_W-1:0] start_o,
  output logic [OP_W-1:0] incr_o
);
  logic [IMM_W-1:0] lo_fld, hi_fld;
  logic [OP_W-1:0]  lo_sext, hi_sext;

  assign lo_fld  = insn_i[9:5];
  assign hi_fld  = insn_i[20:16];
  assign lo_sext = {{(OP_W-IMM_W){lo_fld[IMM_W-1]}}, lo_fld};
  assign hi_sext = {{(OP_W-IMM_W){hi_fld[IMM_W-1]}}, hi_fld};

  assign legal_o = (insn_i[31:24] == 8'h04) && insn_i[21] && (insn_i[15:12] == 4'b0100);
  assign esz_o   = esz_e'(insn_i[23:22]);
  assign rd_o    = insn_i[4:0];
  // bit 10 picks a register start, bit 11 a register step
  assign start_o = insn_i[10] ? start_reg_i : lo_sext;
  assign incr_o  = insn_i[11] ? incr_reg_i  : hi_sext;
endmodule

// File: rtl/vig_lanes.sv
module vig_lanes
  import vig_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  esz_e            esz_i,
  input  logic [OP_W-1:0] start_i,
  input  logic [OP_W-1:0] incr_i,
  output logic [VLEN-1:0] vec_o
);
  logic [VLEN-1:0] seq_w [NUM_ESZ];

  for (genvar g = 0; g < NUM_ESZ; g++) begin : g_width
    localparam int unsigned W     = 8 << g;
    localparam int unsigned LANES = VLEN / W;
    logic [W-1:0] s_w, c_w;
    // truncating to W also keeps narrow lanes inside the low 32 bits
    assign s_w = start_i[W-1:0];
    assign c_w = incr_i[W-1:0];
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam logic [W-1:0] IDX = W'(l);
      assign seq_w[g][l*W +: W] = s_w + IDX * c_w;
    end
  end

  assign vec_o = seq_w[esz_i];
endmodule

// File: rtl/vec_index_gen.sv
module vec_index_gen
  import vig_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     insn_i,
  input  logic [63:0]     start_reg_i,
  input  logic [63:0]     incr_reg_i,
  output logic [VLEN-1:0] vec_o,
  output logic [4:0]      rd_o,
  output logic            done_o,
  output logic            illegal_o
);
  logic            legal;
  esz_e            esz;
  logic [4:0]      rd_d;
  logic [OP_W-1:0] start_v, incr_v;
  logic [VLEN-1:0] vec_d;

  vig_decode u_decode (
    .insn_i      (insn_i),
    .start_reg_i (start_reg_i),
    .incr_reg_i  (incr_reg_i),
    .legal_o     (legal),
    .esz_o       (esz),
    .rd_o        (rd_d),
    .start_o     (start_v),
    .incr_o      (incr_v)
  );

  vig_lanes #(.VLEN(VLEN)) u_lanes (
    .esz_i   (esz),
    .start_i (start_v),
    .incr_i  (incr_v),
    .vec_o   (vec_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o     <= '0;
      rd_o      <= '0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o    <= valid_i && legal;
      illegal_o <= valid_i && !legal;
      if (valid_i && legal) begin
        vec_o <= vec_d;
        rd_o  <= rd_d;
      end
    end
  end

  a_r1_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && illegal_o));
  a_r2_vec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $stable(vec_o));
  a_r2_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $stable(rd_o));
  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o || $past(valid_i));
  a_r12_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o && !illegal_o && $stable(vec_o));
endmodule

// File: tb/vec_index_gen_bench.sv
module vec_index_gen_bench;
  localparam int unsigned VLEN = 256;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned NVEC = 18;
  localparam int unsigned WATCHDOG = 5000;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [31:0]     insn_i = '0;
  logic [63:0]     start_reg_i = '0;
  logic [63:0]     incr_reg_i = '0;
  logic [VLEN-1:0] vec_o;
  logic [4:0]      rd_o;
  logic            done_o, illegal_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  vec_index_gen #(.VLEN(VLEN)) u_vec_index_gen (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
    .start_reg_i(start_reg_i), .incr_reg_i(incr_reg_i),
    .vec_o(vec_o), .rd_o(rd_o), .done_o(done_o), .illegal_o(illegal_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {esz[2], form[2], f20_16[5], f9_5[5], rd[5], start_reg[64], incr_reg[64]}
  localparam logic [146:0] TBL [NVEC] = '{
    {2'd0, 2'b00, 5'd1,  5'd0,  5'd1,  64'h0, 64'h0},
    {2'd1, 2'b00, 5'd3,  5'd7,  5'd2,  64'h0, 64'h0},
    {2'd2, 2'b00, 5'h1d, 5'd2,  5'd3,  64'h0, 64'h0},
    {2'd3, 2'b00, 5'h1f, 5'h10, 5'd4,  64'h0, 64'h0},
    {2'd0, 2'b10, 5'd9,  5'd5,  5'd5,  64'h0, 64'hffff_0000_0000_0013},
    {2'd1, 2'b10, 5'd9,  5'h1e, 5'd6,  64'h0, 64'h8000_0001_0000_0100},
    {2'd2, 2'b10, 5'd9,  5'd3,  5'd7,  64'h0, 64'h1234_5678_ffff_fffe},
    {2'd3, 2'b10, 5'd9,  5'd3,  5'd8,  64'h0, 64'h1234_5678_ffff_fffe},
    {2'd0, 2'b01, 5'h1d, 5'd0,  5'd9,  64'hdead_beef_0000_00f0, 64'h0},
    {2'd1, 2'b01, 5'd4,  5'd0,  5'd10, 64'h0000_0001_0000_fffc, 64'h0},
    {2'd2, 2'b01, 5'h11, 5'd0,  5'd11, 64'hdead_beef_0000_0011, 64'h0},
    {2'd3, 2'b01, 5'h11, 5'd0,  5'd12, 64'hdead_beef_0000_0011, 64'h0},
    {2'd0, 2'b11, 5'd0,  5'd0,  5'd13, 64'h1111_2222_3333_4480, 64'h5555_6666_0000_0011},
    {2'd1, 2'b11, 5'd0,  5'd0,  5'd14, 64'h7777_0000_0000_8000, 64'h0000_0001_0000_f000},
    {2'd2, 2'b11, 5'd0,  5'd0,  5'd15, 64'hffff_ffff_8000_0000, 64'hcafe_0000_4000_0000},
    {2'd3, 2'b11, 5'd0,  5'd0,  5'd31, 64'hffff_ffff_ffff_fff0, 64'h4000_0000_0000_0003},
    {2'd0, 2'b00, 5'd15, 5'd15, 5'd16, 64'h0, 64'h0},
    {2'd3, 2'b00, 5'h10, 5'h0f, 5'd17, 64'h0, 64'h0}
  };

  function automatic logic [31:0] mk_insn(logic [1:0] esz, logic [1:0] form,
                                          logic [4:0] hi, logic [4:0] lo, logic [4:0] rd);
    return {8'h04, esz, 1'b1, hi, 4'b0100, form, lo, rd};
  endfunction

  function automatic logic [63:0] sx5(logic [4:0] v);
    return {{59{v[4]}}, v};
  endfunction

  // explicit per-lane wraparound reference
  function automatic logic [VLEN-1:0] ref_vec(int esz, logic [63:0] s, logic [63:0] c);
    int w = 8 << esz;
    logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    logic [VLEN-1:0] r = '0;
    if (w < 64) begin
      s = {32'd0, s[31:0]};
      c = {32'd0, c[31:0]};
    end
    for (int i = 0; i < VLEN / w; i++) begin
      logic [63:0] v = (s + 64'(i) * c) & mask;
      r = r | (VLEN'(v) << (i * w));
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] w, logic [63:0] s, logic [63:0] c);
    @(negedge clk);
    insn_i = w; start_reg_i = s; incr_reg_i = c; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int k = 0; k < WATCHDOG; k++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=1 exp=0");
    finish_run();
  end

  initial begin
    logic [VLEN-1:0] exp_v, held_v;
    logic [4:0] held_rd;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(vec_o == '0 && rd_o == '0 && !done_o && !illegal_o, "R11 reset", vec_o, '0);
    rst_ni = 1'b1;

    // R3 R4 R5 R6 R7 R8 R9 R10 table walk
    for (int n = 0; n < NVEC; n++) begin
      logic [146:0] e = TBL[n];
      logic [1:0] esz = e[146:145];
      logic [1:0] form = e[144:143];
      logic [4:0] hi = e[142:138], lo = e[137:133], rd = e[132:128];
      logic [63:0] sr = e[127:64], ir = e[63:0];
      logic [63:0] st = form[0] ? sr : sx5(lo);
      logic [63:0] ic = form[1] ? ir : sx5(hi);
      exp_v = ref_vec(int'(esz), st, ic);
      issue(mk_insn(esz, form, hi, lo, rd), sr, ir);
      chk(vec_o == exp_v, $sformatf("R3-6/R7/R8/R9/R10 vec entry %0d", n), vec_o, exp_v);
      chk(done_o && !illegal_o, "R11 done pulse", VLEN'({done_o, illegal_o}), VLEN'(2'b10));
      chk(rd_o == rd, "R11 rd", VLEN'(rd_o), VLEN'(rd));
    end
    @(negedge clk);
    chk(!done_o, "R11 pulse ends", VLEN'(done_o), '0);

    // R10 explicit descending 8-bit: start 0, step -1 -> lane1 = 0xff
    issue(mk_insn(2'd0, 2'b00, 5'h1f, 5'd0, 5'd3), 64'h0, 64'h0);
    chk(vec_o[15:0] == 16'hff00, "R10 descending", VLEN'(vec_o[15:0]), VLEN'(16'hff00));
    // R7 lane placement, 64-bit lanes, step 1
    issue(mk_insn(2'd3, 2'b00, 5'd1, 5'd0, 5'd3), 64'h0, 64'h0);
    chk(vec_o[127:64] == 64'd1 && vec_o[63:0] == 64'd0, "R7 lane order", vec_o, ref_vec(3, 0, 1));

    held_v = vec_o; held_rd = rd_o;
    // R1 R2 wrong nibble, then wrong opcode
    issue(32'h0420_5000, 64'h5, 64'h5);
    chk(illegal_o && !done_o, "R1 illegal nibble", VLEN'({illegal_o, done_o}), VLEN'(2'b10));
    chk(vec_o == held_v && rd_o == held_rd, "R2 hold after illegal", vec_o, held_v);
    issue(32'h0520_4000, 64'h5, 64'h5);
    chk(illegal_o && !done_o, "R1 illegal opcode", VLEN'({illegal_o, done_o}), VLEN'(2'b10));
    issue(32'h0400_4000, 64'h5, 64'h5);
    chk(illegal_o && vec_o == held_v, "R1 R2 bit21 clear", vec_o, held_v);
    @(negedge clk);
    chk(!illegal_o, "R1 illegal pulse ends", VLEN'(illegal_o), '0);

    // R12 legal word with valid low is ignored
    @(negedge clk);
    insn_i = mk_insn(2'd0, 2'b00, 5'd2, 5'd9, 5'd20); valid_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(!done_o && !illegal_o && vec_o == held_v && rd_o == held_rd, "R12 idle", vec_o, held_v);

    finish_run();
  end
endmodule